// File: doc/BRIEF.md
# Multi-SIMD Wavefront Issue Scheduler

This block decides which resident wavefront issues next on a compute unit built from four 16-lane vector SIMD units. Each SIMD owns a private pool of ten wavefront slots. A wavefront is placed in a slot when it launches, stays on that SIMD until it retires, and is never moved to another SIMD. Each slot keeps a residency flag, a memory-wait flag and an age counter.

One SIMD is visited per clock, in the fixed order 0, 1, 2, 3, 0, and so on. On its visit the scheduler takes the oldest slot of that SIMD that is resident and not waiting on memory. It then drives that SIMD's lane-group counter through four beats, because a 64-thread wavefront is fed to 16 lanes over four cycles. Each SIMD comes round again every fourth cycle, so a new issue can begin straight after the last beat of the previous one. Launch requests are answered at once, in the same cycle, with the slot the wavefront will take or with a busy indication. Retire events and memory request and return events update the slot flags.

Top module: `wave_issue_sched`

## Requirements
- R1: After reset no grant is asserted, no lane is active, every slot is free, and the first cycle after reset visits SIMD 0.
- R2: The visited SIMD advances by one each cycle, wrapping from 3 to 0. Two grants in consecutive cycles carry consecutive SIMD indices.
- R3: A started issue drives lane_active for its SIMD during four consecutive cycles. The beat counter takes the values 0, 1, 2, 3 in turn and the slot stays fixed.
- R4: A pick made while a SIMD is visited appears on grant_valid/grant_simd/grant_slot in the next cycle. In that same cycle the SIMD's lane shows beat 0 with the same slot.
- R5: A memory-request event sets the wait flag of the tagged slot, and that slot is excluded from every visit that follows. A memory-return event clears the flag. If both events name the same slot in one cycle, the request wins.
- R6: Among eligible slots the one with the largest age wins. Age resets to 0 at launch, rises by one each cycle while the slot is resident, and saturates at its maximum. On equal ages the lowest slot index wins.
- R7: When the visited SIMD has no slot that is both resident and free of a memory wait, no grant appears in the following cycle, and the rotation continues regardless.
- R8: A launch takes the lowest-numbered free slot of the requested SIMD. launch_slot shows that slot combinationally in the same cycle, and the slot is resident from the next cycle.
- R9: launch_busy is high in the same cycle whenever all ten slots of the requested SIMD are occupied. A launch made while busy changes no slot.
- R10: A retire event frees the tagged slot and clears its wait flag. The slot is never granted again until it is launched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request |
| launch_simd | input | 2 | Target SIMD of the launch |
| launch_busy | output | 1 | Target SIMD full, launch refused |
| launch_slot | output | 4 | Slot the launch will occupy |
| retire_valid | input | 1 | Retire event |
| retire_simd | input | 2 | SIMD of the retiring wavefront |
| retire_slot | input | 4 | Slot of the retiring wavefront |
| mreq_valid | input | 1 | Memory-request event |
| mreq_simd | input | 2 | SIMD of the requesting wavefront |
| mreq_slot | input | 4 | Slot of the requesting wavefront |
| mret_valid | input | 1 | Memory-return event |
| mret_simd | input | 2 | SIMD of the returning wavefront |
| mret_slot | input | 4 | Slot of the returning wavefront |
| grant_valid | output | 1 | New issue started |
| grant_simd | output | 2 | SIMD of the new issue |
| grant_slot | output | 4 | Slot of the new issue |
| lane_active | output | 4 | Per-SIMD issue in progress |
| lane_slot | output | 16 | Per-SIMD issuing slot, 4 bits per SIMD |
| lane_beat | output | 8 | Per-SIMD lane-group counter, 2 bits per SIMD |

## Verification
The launch answers on launch_busy and launch_slot are due in the cycle of the request. The bench reads them a moment after it drives the inputs. Grants are due one cycle after the visit that makes them, and the lane beats follow over the next three cycles. Every flag change from a launch, retire or memory event is first seen by the visit after the clock edge that takes it in. The bench's model steps on each rising edge, and all registered outputs are compared with it on the falling edge that follows, so each result is checked in exactly the cycle it is due.

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 10,
  parameter int BEATS    = 4,
  parameter int AGE_W    = 8,
  localparam int SIW = $clog2(NUM_SIMD),
  localparam int SLW = $clog2(SLOTS),
  localparam int BW  = $clog2(BEATS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch_valid,
  input  logic [SIW-1:0]        launch_simd,
  output logic                  launch_busy,
  output logic [SLW-1:0]        launch_slot,
  input  logic                  retire_valid,
  input  logic [SIW-1:0]        retire_simd,
  input  logic [SLW-1:0]        retire_slot,
  input  logic                  mreq_valid,
  input  logic [SIW-1:0]        mreq_simd,
  input  logic [SLW-1:0]        mreq_slot,
  input  logic                  mret_valid,
  input  logic [SIW-1:0]        mret_simd,
  input  logic [SLW-1:0]        mret_slot,
  output logic                  grant_valid,
  output logic [SIW-1:0]        grant_simd,
  output logic [SLW-1:0]        grant_slot,
  output logic [NUM_SIMD-1:0]   lane_active,
  output logic [NUM_SIMD*SLW-1:0] lane_slot,
  output logic [NUM_SIMD*BW-1:0]  lane_beat
);

  logic [NUM_SIMD-1:0][SLOTS-1:0] res, wt;
  logic [AGE_W-1:0] age [NUM_SIMD][SLOTS];
  logic [SIW-1:0]   rr;
  logic [NUM_SIMD-1:0] act;
  logic [SLW-1:0]   aslot [NUM_SIMD];
  logic [BW-1:0]    abeat [NUM_SIMD];

  logic             found;
  logic [SLW-1:0]   pick;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    found = 1'b0;
    pick = '0;
    best_age = '0;
    for (int i = 0; i < SLOTS; i++)
      if (res[rr][i] && !wt[rr][i] && (!found || age[rr][i] > best_age)) begin
        found = 1'b1;
        pick = SLW'(i);
        best_age = age[rr][i];
      end
  end

  assign launch_busy = &res[launch_simd];

  always_comb begin
    launch_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!res[launch_simd][i]) launch_slot = SLW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr <= '0;
      res <= '0;
      wt <= '0;
      act <= '0;
      grant_valid <= 1'b0;
      grant_simd <= '0;
      grant_slot <= '0;
      for (int s = 0; s < NUM_SIMD; s++) begin
        aslot[s] <= '0;
        abeat[s] <= '0;
        for (int i = 0; i < SLOTS; i++) age[s][i] <= '0;
      end
    end else begin
      rr <= (rr == SIW'(NUM_SIMD - 1)) ? '0 : rr + 1'b1;
      grant_valid <= found;
      grant_simd <= rr;
      grant_slot <= pick;
      for (int s = 0; s < NUM_SIMD; s++) begin
        if (rr == SIW'(s) && found) begin
          act[s] <= 1'b1;
          aslot[s] <= pick;
          abeat[s] <= '0;
        end else if (act[s]) begin
          if (abeat[s] == BW'(BEATS - 1)) act[s] <= 1'b0;
          else abeat[s] <= abeat[s] + 1'b1;
        end
        for (int i = 0; i < SLOTS; i++)
          if (res[s][i] && age[s][i] != '1) age[s][i] <= age[s][i] + 1'b1;
      end
      if (retire_valid) begin
        res[retire_simd][retire_slot] <= 1'b0;
        wt[retire_simd][retire_slot] <= 1'b0;
      end
      if (mret_valid) wt[mret_simd][mret_slot] <= 1'b0;
      if (mreq_valid) wt[mreq_simd][mreq_slot] <= 1'b1;
      if (launch_valid && !launch_busy) begin
        res[launch_simd][launch_slot] <= 1'b1;
        wt[launch_simd][launch_slot] <= 1'b0;
        age[launch_simd][launch_slot] <= '0;
      end
    end
  end

  assign lane_active = act;

  for (genvar g = 0; g < NUM_SIMD; g++) begin : g_lane
    assign lane_slot[g*SLW +: SLW] = aslot[g];
    assign lane_beat[g*BW +: BW]   = abeat[g];

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      act[g] && abeat[g] != BW'(BEATS - 1) |=>
        act[g] && abeat[g] == BW'($past(abeat[g]) + 1'b1) && aslot[g] == $past(aslot[g])); // R3
  end

  AST_GRANT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(grant_valid) && grant_valid |-> grant_simd == SIW'($past(grant_simd) + 1'b1)); // R2

  AST_GRANT_OPENS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> act[grant_simd] && abeat[grant_simd] == '0 && aslot[grant_simd] == grant_slot); // R4

  AST_GRANT_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> res[grant_simd][grant_slot] || $past(retire_valid)); // R10

  AST_LAUNCH_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && !launch_busy && !retire_valid |=>
      $countones(res) == $past($countones(res)) + 1); // R8

  AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && launch_busy && !retire_valid |=> res == $past(res)); // R9

endmodule

// File: tb/wave_issue_sched_tb_top.sv
module wave_issue_sched_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_valid = 0, retire_valid = 0, mreq_valid = 0, mret_valid = 0;
  logic [1:0] launch_simd = 0, retire_simd = 0, mreq_simd = 0, mret_simd = 0;
  logic [3:0] retire_slot = 0, mreq_slot = 0, mret_slot = 0;
  logic launch_busy, grant_valid;
  logic [3:0] launch_slot, grant_slot;
  logic [1:0] grant_simd;
  logic [3:0] lane_active;
  logic [15:0] lane_slot;
  logic [7:0] lane_beat;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wave_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_simd(launch_simd),
    .launch_busy(launch_busy), .launch_slot(launch_slot),
    .retire_valid(retire_valid), .retire_simd(retire_simd), .retire_slot(retire_slot),
    .mreq_valid(mreq_valid), .mreq_simd(mreq_simd), .mreq_slot(mreq_slot),
    .mret_valid(mret_valid), .mret_simd(mret_simd), .mret_slot(mret_slot),
    .grant_valid(grant_valid), .grant_simd(grant_simd), .grant_slot(grant_slot),
    .lane_active(lane_active), .lane_slot(lane_slot), .lane_beat(lane_beat)
  );

  // behavioural reference
  bit m_res[4][10], m_wt[4][10];
  int m_age[4][10];
  bit m_act[4];
  int m_slot[4], m_beat[4];
  int m_rr, m_gs, m_gsl;
  bit m_gv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rr = 0; m_gv = 0; m_gs = 0; m_gsl = 0;
      for (int s = 0; s < 4; s++) begin
        m_act[s] = 0; m_slot[s] = 0; m_beat[s] = 0;
        for (int i = 0; i < 10; i++) begin m_res[s][i] = 0; m_wt[s][i] = 0; m_age[s][i] = 0; end
      end
    end else begin
      int best;
      int fs;
      best = -1;
      for (int i = 0; i < 10; i++)
        if (m_res[m_rr][i] && !m_wt[m_rr][i] && (best < 0 || m_age[m_rr][i] > m_age[m_rr][best])) best = i;
      fs = -1;
      for (int i = 9; i >= 0; i--) if (!m_res[launch_simd][i]) fs = i;
      for (int s = 0; s < 4; s++) begin
        if (s == m_rr && best >= 0) begin m_act[s] = 1; m_slot[s] = best; m_beat[s] = 0; end
        else if (m_act[s]) begin
          if (m_beat[s] == 3) m_act[s] = 0; else m_beat[s]++;
        end
        for (int i = 0; i < 10; i++) if (m_res[s][i] && m_age[s][i] < 255) m_age[s][i]++;
      end
      m_gv = (best >= 0); m_gs = m_rr; m_gsl = (best >= 0) ? best : 0;
      if (retire_valid) begin m_res[retire_simd][retire_slot] = 0; m_wt[retire_simd][retire_slot] = 0; end
      if (mret_valid) m_wt[mret_simd][mret_slot] = 0;
      if (mreq_valid) m_wt[mreq_simd][mreq_slot] = 1;
      if (launch_valid && fs >= 0) begin m_res[launch_simd][fs] = 1; m_wt[launch_simd][fs] = 0; m_age[launch_simd][fs] = 0; end
      m_rr = (m_rr + 1) % 4;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(grant_valid == m_gv, "R7 grant_valid", grant_valid, m_gv);
    if (m_gv) begin
      chk(grant_simd == m_gs, "R2 grant_simd", grant_simd, m_gs);
      chk(grant_slot == m_gsl, "R4 grant_slot", grant_slot, m_gsl);
    end
    for (int s = 0; s < 4; s++) begin
      chk(lane_active[s] == m_act[s], "R3 lane_active", lane_active[s], m_act[s]);
      if (m_act[s]) begin
        chk(lane_beat[s*2 +: 2] == m_beat[s], "R3 lane_beat", lane_beat[s*2 +: 2], m_beat[s]);
        chk(lane_slot[s*4 +: 4] == m_slot[s], "R3 lane_slot", lane_slot[s*4 +: 4], m_slot[s]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(input int simd, input int exp_slot, input bit exp_busy);
    launch_valid = 1; launch_simd = 2'(simd);
    #1;
    chk(launch_busy == exp_busy, "R9 launch_busy", launch_busy, exp_busy);
    if (!exp_busy) chk(launch_slot == 4'(exp_slot), "R8 launch_slot", launch_slot, exp_slot);
    @(negedge clk);
    launch_valid = 0;
  endtask

  task automatic retire(input int simd, input int slot);
    retire_valid = 1; retire_simd = 2'(simd); retire_slot = 4'(slot);
    @(negedge clk);
    retire_valid = 0;
  endtask

  task automatic mem_req(input int simd, input int slot);
    mreq_valid = 1; mreq_simd = 2'(simd); mreq_slot = 4'(slot);
    @(negedge clk);
    mreq_valid = 0;
  endtask

  task automatic mem_ret(input int simd, input int slot);
    mret_valid = 1; mret_simd = 2'(simd); mret_slot = 4'(slot);
    @(negedge clk);
    mret_valid = 0;
  endtask

  // next grant of a SIMD within one rotation; exp_slot < 0 means none expected
  task automatic expect_grant(input int simd, input int exp_slot, input string tag);
    bit seen;
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (grant_valid && grant_simd == 2'(simd) && !seen) begin
        seen = 1;
        chk(exp_slot >= 0 && grant_slot == 4'(exp_slot), tag, grant_slot, exp_slot);
      end
    end
    if (!seen) chk(exp_slot < 0, tag, -1, exp_slot);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    launch_simd = 0;
    #1;
    chk(grant_valid == 0, "R1 grant idle", grant_valid, 0);
    chk(lane_active == 0, "R1 lanes idle", lane_active, 0);
    chk(launch_busy == 0, "R1 not busy", launch_busy, 0);
    chk(launch_slot == 0, "R1 slot0 free", launch_slot, 0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    idle(8);                                           // R7 nothing resident
    for (int s = 0; s < 4; s++) launch(s, 0, 0);      // R8
    idle(12);                                          // R2 R3 R4 via model
    for (int i = 1; i < 10; i++) launch(2, i, 0);
    launch(2, 0, 1);                                   // R9 full
    launch(2, 0, 1);
    idle(4);
    retire(2, 4);                                      // R10
    launch(2, 4, 0);                                   // R8 reuses lowest free
    launch(1, 1, 0);
    retire(1, 0);
    expect_grant(1, 1, "R10 retired slot not granted");
    launch(1, 0, 0);                                   // younger slot 0
    idle(2);
    expect_grant(1, 1, "R6 oldest wins");
    mem_req(1, 1);
    expect_grant(1, 0, "R5 waiting slot skipped");
    mem_req(1, 0);
    expect_grant(1, -1, "R7 no eligible slot");
    mem_ret(1, 1);
    expect_grant(1, 1, "R5 return re-enables");
    mreq_valid = 1; mreq_simd = 1; mreq_slot = 1;      // R5 request beats return
    mret_valid = 1; mret_simd = 1; mret_slot = 1;
    @(negedge clk);
    mreq_valid = 0; mret_valid = 0;
    expect_grant(1, -1, "R5 request wins over return");
    mem_ret(1, 0);
    mem_ret(1, 1);
    launch(3, 1, 0);
    idle(300);                                         // ages saturate
    expect_grant(3, 0, "R6 tie goes to lowest index");
    mem_req(3, 0);
    expect_grant(3, 1, "R5 skip to other slot");
    idle(8);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule